// File: doc/BRIEF.md
# Bidirectional Turbine Pulse Meter

This block turns the two optical pickups of a rotating-vane flow turbine into a signed volume count and a flow-rate measurement. The pickups produce square waves a quarter period apart; which one leads tells the direction of airflow. The vane breaks each beam twice per turn, so each channel produces two pulses per revolution.

Both lines are raw asynchronous inputs. Each is resynchronised, then passed through a digital glitch filter. A rising edge on channel A counts one pulse. The level of channel B at that edge gives the direction. Each counted pulse moves a signed accumulator up or down by one. The same pulse latches the number of clock ticks since the previous counted pulse, which is the pulse period. Software converts the count into volume and the reciprocal of the period into flow, each by a constant factor. If no pulse arrives before the period counter runs out, the block raises a stalled flag and reports a period of zero, meaning no flow. A clear command zeroes the volume count and leaves the period measurement alone.

Top module: `turbine_pulse_meter`

## Requirements
- R1: Each sensor line passes through a two-stage synchronizer and then a filter. The filter output changes only after FILT_LEN consecutive equal synchronized samples. A sensor level that lasts fewer than FILT_LEN clocks never produces a count or a strobe.
- R2: A rising edge of filtered channel A while filtered channel B is 0 adds one to `vol_count` and sets `dir_up` to 1.
- R3: A rising edge of filtered channel A while filtered channel B is 1 subtracts one from `vol_count` and sets `dir_up` to 0.
- R4: If both filtered channels change in the same clock, nothing is counted: `vol_count`, `dir_up` and `sample_stb` are unaffected.
- R5: `vol_count` is two's complement of width ACC_W and wraps modulo 2^ACC_W. Counting up from 2^(ACC_W-1)-1 gives -2^(ACC_W-1), and counting down from 0 gives all ones.
- R6: `period` holds the number of clock cycles between the two most recent counted pulses, latched when a pulse is counted. Between counted pulses it does not change, except as R8 forces it to zero.
- R7: `sample_stb` is high for exactly one cycle for each counted pulse. It rises in the same cycle that `period` takes its new value.
- R8: The tick counter saturates at 2^PER_W-1. When it saturates, `stalled` goes to 1 and `period` reads 0. The next counted pulse clears `stalled` and latches the saturated value 2^PER_W-1.
- R9: A one-cycle `clear` makes `vol_count` 0 on the next cycle, even if a pulse is counted in the same cycle. `period` and `stalled` are not affected.
- R10: After reset, `vol_count`, `period`, `sample_stb` and `stalled` are 0 and `dir_up` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous zeroing of the volume count |
| sens_a | input | 1 | Raw optical channel A (counting channel) |
| sens_b | input | 1 | Raw optical channel B (direction channel) |
| vol_count | output | ACC_W | Signed pulse accumulator |
| dir_up | output | 1 | Direction of the last counted pulse, 1 = up |
| period | output | PER_W | Clock ticks between the last two counted pulses; 0 while stalled |
| sample_stb | output | 1 | One-cycle strobe when a new period is latched |
| stalled | output | 1 | Period counter has saturated with no new pulse |

## Verification
The bench fires one-cycle and two-cycle glitches on channel A. A filter that let them through would add counts and strobes while the turbine was at rest. It drives both channels from 00 to 11 and back in the same cycle. A decoder that did not reject a double step would count a phantom pulse in an unknown direction. It counts across the signed wrap point and down from zero. An adder that saturated or was sized wrong would stop at the limit instead of wrapping. It also lets the period counter run out and then restarts the flow, so a design that failed to force zero during a stall, or failed to release the flag on the next pulse, would show a wrong period. A random walk of forward and backward steps with random hold times confirms that every reversal lands on the count the bench's own model predicts.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  typedef struct packed {
    logic pulse;
    logic up;
  } tpm_event_t;

  localparam int unsigned TPM_CHANNELS = 2;

  function automatic logic tpm_rising(input logic prev_v, input logic cur_v);
    return cur_v & ~prev_v;
  endfunction

  function automatic logic tpm_both_moved(input logic pa, input logic pb,
                                          input logic fa, input logic fb);
    return (pa ^ fa) & (pb ^ fb);
  endfunction

endpackage

// File: rtl/tpm_input_cond.sv
module tpm_input_cond #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);

  localparam int unsigned SYNC_TOP = SYNC_STAGES - 1;
  localparam int unsigned HIST_TOP = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   filt_q;
  logic                   sync_out;

  assign sync_out = sync_q[SYNC_TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_TOP-1:0], raw_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[HIST_TOP-1:0], sync_out};
      if (&hist_q) begin
        filt_q <= 1'b1;
      end else if (~|hist_q) begin
        filt_q <= 1'b0;
      end
    end
  end

  assign filt_o = filt_q;

  AST_FILT_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> $past(sync_out, 2)); // R1
  AST_FILT_FALL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> !$past(sync_out, 2)); // R1

endmodule

// File: rtl/tpm_edge_decoder.sv
module tpm_edge_decoder
  import tpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fa_i,
  input  logic       fb_i,
  output tpm_event_t ev_o,
  output logic       double_step_o
);

  logic pa_q;
  logic pb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
    end else begin
      pa_q <= fa_i;
      pb_q <= fb_i;
    end
  end

  always_comb begin
    double_step_o = tpm_both_moved(pa_q, pb_q, fa_i, fb_i);
    ev_o.pulse    = tpm_rising(pa_q, fa_i) & ~double_step_o;
    ev_o.up       = ~fb_i;
  end

endmodule

// File: rtl/tpm_accum.sv
module tpm_accum
  import tpm_pkg::*;
#(
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  tpm_event_t       ev_i,
  output logic [ACC_W-1:0] count_o,
  output logic             dir_up_o
);

  localparam logic [ACC_W-1:0] ONE = ACC_W'(1);

  logic [ACC_W-1:0] count_q;
  logic             dir_q;

  function automatic logic [ACC_W-1:0] step_count(input logic [ACC_W-1:0] v,
                                                  input logic up);
    return up ? (v + ONE) : (v - ONE);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      dir_q   <= 1'b1;
    end else begin
      if (clear_i) begin
        count_q <= '0;
      end else if (ev_i.pulse) begin
        count_q <= step_count(count_q, ev_i.up);
      end
      if (ev_i.pulse) begin
        dir_q <= ev_i.up;
      end
    end
  end

  assign count_o  = count_q;
  assign dir_up_o = dir_q;

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.pulse && ev_i.up && !clear_i) |=> (count_q == $past(count_q) + ONE)); // R2
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.pulse && !ev_i.up && !clear_i) |=> (count_q == $past(count_q) - ONE)); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_q == '0)); // R9
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_i.pulse && !clear_i) |=> $stable(count_q)); // R4

endmodule

// File: rtl/tpm_period_timer.sv
module tpm_period_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  output logic [PER_W-1:0] period_o,
  output logic             stb_o,
  output logic             stalled_o
);

  localparam logic [PER_W-1:0] CNT_MAX = '1;
  localparam logic [PER_W-1:0] ONE     = PER_W'(1);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per_q;
  logic             stb_q;
  logic             stall_q;
  logic [PER_W-1:0] cnt_next;

  function automatic logic [PER_W-1:0] sat_inc(input logic [PER_W-1:0] v);
    return (v == CNT_MAX) ? v : (v + ONE);
  endfunction

  assign cnt_next = sat_inc(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      stb_q   <= 1'b0;
      stall_q <= 1'b0;
    end else if (pulse_i) begin
      per_q   <= cnt_next;
      cnt_q   <= '0;
      stb_q   <= 1'b1;
      stall_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      stb_q <= 1'b0;
      if (cnt_next == CNT_MAX) begin
        stall_q <= 1'b1;
      end
    end
  end

  assign period_o  = stall_q ? '0 : per_q;
  assign stb_o     = stb_q;
  assign stalled_o = stall_q;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R7
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_i |=> $stable(per_q)); // R6
  AST_STALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> (period_o == '0)); // R8
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> !stall_q); // R8

endmodule

// File: rtl/turbine_pulse_meter.sv
module turbine_pulse_meter
  import tpm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned ACC_W       = 24,
  parameter int unsigned PER_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sens_a,
  input  logic             sens_b,
  output logic [ACC_W-1:0] vol_count,
  output logic             dir_up,
  output logic [PER_W-1:0] period,
  output logic             sample_stb,
  output logic             stalled
);

  logic [TPM_CHANNELS-1:0] raw_vec;
  logic [TPM_CHANNELS-1:0] filt_vec;
  tpm_event_t              ev;
  logic                    double_step;

  assign raw_vec = {sens_b, sens_a};

  for (genvar ch = 0; ch < TPM_CHANNELS; ch++) begin : g_chan
    tpm_input_cond #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_vec[ch]),
      .filt_o(filt_vec[ch])
    );
  end

  tpm_edge_decoder u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .fa_i         (filt_vec[0]),
    .fb_i         (filt_vec[1]),
    .ev_o         (ev),
    .double_step_o(double_step)
  );

  tpm_accum #(.ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear),
    .ev_i    (ev),
    .count_o (vol_count),
    .dir_up_o(dir_up)
  );

  tpm_period_timer #(.PER_W(PER_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_i  (ev.pulse),
    .period_o (period),
    .stb_o    (sample_stb),
    .stalled_o(stalled)
  );

  AST_DOUBLE_STEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    double_step |=> !sample_stb); // R4
  AST_STB_ON_A_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ev.pulse |-> (filt_vec[0] && !$past(filt_vec[0]))); // R2
  AST_DIR_FOLLOWS_B: assert property (@(posedge clk) disable iff (!rst_n)
    ev.pulse |=> (dir_up == !$past(filt_vec[1]))); // R3

endmodule

// File: tb/turbine_pulse_meter_bench.sv
module turbine_pulse_meter_bench;

  localparam int unsigned ACC_W    = 8;
  localparam int unsigned PER_W    = 10;
  localparam int unsigned FILT_LEN = 3;
  localparam int          PER_MAX  = (1 << PER_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clear = 1'b0;
  logic             sens_a = 1'b0;
  logic             sens_b = 1'b0;
  logic [ACC_W-1:0] vol_count;
  logic             dir_up;
  logic [PER_W-1:0] period;
  logic             sample_stb;
  logic             stalled;

  int checks = 0;
  int errors = 0;
  int exp_count = 0;
  bit exp_dir = 1'b1;
  int exp_stb = 0;
  int stb_seen = 0;
  int last_per = 0;
  bit prev_stb = 1'b0;
  bit cur_a = 1'b0;
  bit cur_b = 1'b0;
  int qpos = 0;

  always #5 clk = ~clk;

  turbine_pulse_meter #(
    .SYNC_STAGES(2),
    .FILT_LEN   (FILT_LEN),
    .ACC_W      (ACC_W),
    .PER_W      (PER_W)
  ) u_turbine_pulse_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .sens_a    (sens_a),
    .sens_b    (sens_b),
    .vol_count (vol_count),
    .dir_up    (dir_up),
    .period    (period),
    .sample_stb(sample_stb),
    .stalled   (stalled)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_stb) begin
        stb_seen++;
        last_per = int'(period);
      end
      if (sample_stb && prev_stb) begin
        chk(1'b0, "R7 strobe longer than one cycle", 2, 1);
      end
      prev_stb = sample_stb;
    end
  end

  function automatic logic [ACC_W-1:0] wrap8(input int v);
    return v[ACC_W-1:0];
  endfunction

  function automatic bit quad_a(input int q);
    return (q == 1) || (q == 2);
  endfunction

  function automatic bit quad_b(input int q);
    return (q == 2) || (q == 3);
  endfunction

  task automatic apply(input bit na, input bit nb, input int hold);
    if (!cur_a && na && (nb == cur_b)) begin
      exp_count += nb ? -1 : 1;
      exp_dir = !nb;
      exp_stb++;
    end
    cur_a = na;
    cur_b = nb;
    sens_a = na;
    sens_b = nb;
    repeat (hold) @(negedge clk);
  endtask

  task automatic step(input bit fwd, input int hold);
    qpos = fwd ? (qpos + 1) % 4 : (qpos + 3) % 4;
    apply(quad_a(qpos), quad_b(qpos), hold);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic check_count(input string req);
    chk(vol_count == wrap8(exp_count), req, vol_count, wrap8(exp_count));
    chk(dir_up == exp_dir, {req, " dir"}, dir_up, exp_dir);
    chk(stb_seen == exp_stb, {req, " strobes"}, stb_seen, exp_stb);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int saved_per;
    bit saved_stall;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(vol_count == 0, "R10 count", vol_count, 0);
    chk(period == 0, "R10 period", period, 0);
    chk(sample_stb == 0, "R10 strobe", sample_stb, 0);
    chk(stalled == 0, "R10 stalled", stalled, 0);
    chk(dir_up == 1, "R10 dir", dir_up, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 short glitches on A with B low are rejected
    sens_a = 1'b1; @(negedge clk); sens_a = 1'b0;
    settle();
    sens_a = 1'b1; repeat (2) @(negedge clk); sens_a = 1'b0;
    settle();
    chk(vol_count == 0, "R1 glitch count", vol_count, 0);
    chk(stb_seen == 0, "R1 glitch strobes", stb_seen, 0);

    // R2 forward rotation, R6 period = 4 * hold
    for (int i = 0; i < 8; i++) step(1'b1, 6);
    settle();
    check_count("R2 forward");
    chk(last_per == 24, "R6 forward period", last_per, 24);

    // R3 reverse rotation
    for (int i = 0; i < 8; i++) step(1'b0, 7);
    settle();
    check_count("R3 reverse");
    chk(last_per == 28, "R6 reverse period", last_per, 28);

    // R4 both channels move together (qpos is 0 here)
    apply(1'b1, 1'b1, 10);
    apply(1'b0, 1'b0, 10);
    settle();
    check_count("R4 double step");

    // R9 clear keeps period and stall state
    step(1'b1, 6); step(1'b1, 6);
    settle();
    saved_per = int'(period);
    saved_stall = stalled;
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    exp_count = 0;
    chk(vol_count == 0, "R9 clear count", vol_count, 0);
    chk(int'(period) == saved_per, "R9 period kept", period, saved_per);
    chk(stalled == saved_stall, "R9 stall kept", stalled, saved_stall);

    // R8 stall, then recovery with saturated period
    repeat (PER_MAX + 80) @(negedge clk);
    chk(stalled == 1, "R8 stalled", stalled, 1);
    chk(period == 0, "R8 zero flow", period, 0);
    step(1'b1, 6); step(1'b1, 6); step(1'b1, 6); step(1'b1, 6);
    settle();
    chk(stalled == 0, "R8 released", stalled, 0);
    chk(last_per == PER_MAX, "R8 saturated period", last_per, PER_MAX);

    // R5 wrap below zero and above the positive limit
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    exp_count = 0;
    for (int i = 0; i < 4; i++) step(1'b0, 5);
    settle();
    chk(vol_count == 8'hFF, "R5 down from zero", vol_count, 8'hFF);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    exp_count = 0;
    for (int i = 0; i < 128 * 4; i++) step(1'b1, 5);
    settle();
    chk(vol_count == 8'h80, "R5 positive wrap", vol_count, 8'h80);
    check_count("R5 wrap model");

    // random walk: R2 R3 R6 via model
    begin
      bit fwd = 1'b1;
      for (int i = 0; i < 300; i++) begin
        if ($urandom_range(9, 0) < 3) fwd = !fwd;
        step(fwd, int'($urandom_range(12, 5)));
        if ((i % 25) == 24) begin
          settle();
          check_count("R2 R3 random walk");
        end
      end
    end

    // constant-rate segment after random walk: R6
    for (int i = 0; i < 12; i++) step(1'b1, 9);
    settle();
    chk(last_per == 36, "R6 steady period", last_per, 36);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule